// File: doc/BRIEF.md
# Strobe-Paced Circular Sample Delay

This block runs a circular delay line over a single-port synchronous byte memory outside the block. Each time the sample strobe fires, it reads the oldest byte in the buffer and returns it as the output sample. It then overwrites that same location with the incoming sample and steps the address on by one. The address always covers the whole buffer. No tap offset is programmable. The delay length is the buffer depth divided by the strobe rate, so sweeping the strobe frequency sweeps the delay. For example, 262144 bytes gives about 8 s at 33 kHz and about 1 s at 261 kHz.

The strobe is expected to be a single-cycle pulse that has already been synchronized to the clock. A read/write pair takes two clock cycles. A strobe that arrives while a pair is running is held and serviced as soon as that pair ends. A parameter shrinks the active depth to a smaller power of two, for smaller memories; the unused upper address bits are then held at zero. Until the buffer has been filled once after reset, the block outputs the mid-scale code so that the output is silent.

Top module: `sample_delay_line`

## Requirements
- R1: The memory address counts 0, 1, ... DEPTH-1 and then returns to 0, one step per serviced strobe. DEPTH is 2^(FULL_ADDR_W-DEPTH_SHIFT). Address bits at or above FULL_ADDR_W-DEPTH_SHIFT stay 0.
- R2: Each serviced strobe makes exactly one read cycle (ram_we=0), followed by exactly one write cycle (ram_we=1) at the same address. The write cycle writes the sample that was present with the strobe.
- R3: For serviced strobe number k, with k > DEPTH and counting from 1, the output sample equals the input sample of strobe k-DEPTH. This holds whatever the spacing between strobes.
- R4: The outputs for the first DEPTH strobes after reset are 0x80.
- R5: out_valid is a one-cycle pulse, one per serviced strobe. For a strobe seen at an idle clock edge, the pulse is high in the second cycle after that edge. out_sample changes only together with the pulse.
- R6: No strobe is dropped or merged when strobes are spaced as either of the following: (a) at least two cycles apart, or (b) two adjacent strobes followed by a gap of at least two cycles. A strobe that arrives while a pair is busy is held and serviced next.
- R7: While reset is held, and until the first strobe, out_sample is 0x80, out_valid is 0, ram_we is 0 and ram_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_strobe | input | 1 | One-cycle sample strobe |
| smp_in | input | SAMPLE_W | Sample stored on the strobe |
| out_sample | output | SAMPLE_W | Delayed sample, held between strobes |
| out_valid | output | 1 | Pulse when out_sample updates |
| ram_addr | output | FULL_ADDR_W | Memory address |
| ram_wdata | output | SAMPLE_W | Memory write data |
| ram_we | output | 1 | Memory write enable (read when low) |
| ram_rdata | input | SAMPLE_W | Memory read data, one cycle after a read |

## Verification
The hardest case to reach is a strobe that lands while a read/write pair is still in flight. It has to be held, and then started directly from the write cycle, with no idle cycle and no loss of its sample. The stimulus holds the strobe high for two adjacent cycles and then leaves a gap of three cycles, many times over. Across all strobe spacings, the scoreboard predicts every write address and data value and every delayed output. The runs go past several wraps of a reduced 16-entry buffer, so the muted fill phase, the first wrap and the steady state are all covered.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;
endpackage

// File: rtl/sdl_ctrl.sv
module sdl_ctrl
  import sdl_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic [SAMPLE_W-1:0] smp_in,
  output logic                rd_cyc,
  output logic                wr_cyc,
  output logic [SAMPLE_W-1:0] wr_data
);
  phase_t              ph_q, ph_d;
  logic                pend_q, pend_d;
  logic [SAMPLE_W-1:0] pend_smp_q;
  logic [SAMPLE_W-1:0] cur_smp_q;
  logic                start;
  logic                busy;
  logic                pend_load;

  assign busy      = (ph_q != PH_IDLE);
  assign start     = (ph_q == PH_IDLE && strobe) || (ph_q == PH_WRITE && (strobe || pend_q));
  assign pend_load = strobe && busy && !(ph_q == PH_WRITE);

  always_comb begin
    ph_d   = ph_q;
    pend_d = pend_q;
    unique case (ph_q)
      PH_IDLE:  if (strobe) ph_d = PH_READ;
      PH_READ:  ph_d = PH_WRITE;
      PH_WRITE: ph_d = start ? PH_READ : PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
    if (pend_load)
      pend_d = 1'b1;
    else if (ph_q == PH_WRITE && pend_q)
      pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      pend_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_smp_q <= '0;
      cur_smp_q  <= '0;
    end else begin
      if (pend_load) pend_smp_q <= smp_in;
      if (start)     cur_smp_q  <= (ph_q == PH_WRITE && pend_q) ? pend_smp_q : smp_in;
    end
  end

  assign rd_cyc  = (ph_q == PH_READ);
  assign wr_cyc  = (ph_q == PH_WRITE);
  assign wr_data = cur_smp_q;

  // R6
  held_strobe_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> ph_q != PH_IDLE);

  // R6
  busy_strobe_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && ph_q == PH_READ) |=> pend_q);
endmodule

// File: rtl/sdl_addr.sv
module sdl_addr #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic              filled
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              filled_q, filled_d;
  logic              at_top;

  assign at_top = (addr_q == {ADDR_W{1'b1}});

  always_comb begin
    addr_d   = addr_q;
    filled_d = filled_q;
    if (adv) begin
      addr_d = addr_q + 1'b1;
      if (at_top) filled_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      filled_q <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      filled_q <= filled_d;
    end
  end

  assign addr   = addr_q;
  assign filled = filled_q;

  // R1
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_top) |=> (addr_q == '0 && filled_q));
endmodule

// File: rtl/sdl_out.sv
module sdl_out #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                live,
  input  logic [SAMPLE_W-1:0] rdata,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic                out_valid
);
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] smp_q, smp_d;
  logic                vld_q;

  always_comb begin
    smp_d = smp_q;
    if (load) smp_d = live ? rdata : MID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= MID;
      vld_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
      vld_q <= load;
    end
  end

  assign out_sample = smp_q;
  assign out_valid  = vld_q;

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample));

  // R4
  muted_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !live) |=> out_sample == MID);
endmodule

// File: rtl/sample_delay_line.sv
module sample_delay_line #(
  parameter int SAMPLE_W    = 8,
  parameter int FULL_ADDR_W = 18,
  parameter int DEPTH_SHIFT = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_strobe,
  input  logic [SAMPLE_W-1:0]    smp_in,
  output logic [SAMPLE_W-1:0]    out_sample,
  output logic                   out_valid,
  output logic [FULL_ADDR_W-1:0] ram_addr,
  output logic [SAMPLE_W-1:0]    ram_wdata,
  output logic                   ram_we,
  input  logic [SAMPLE_W-1:0]    ram_rdata
);
  localparam int ADDR_W = FULL_ADDR_W - DEPTH_SHIFT;

  logic              rst_s1, rst_s2;
  logic              rd_cyc, wr_cyc, filled;
  logic [ADDR_W-1:0] addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  sdl_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s2), .strobe(smp_strobe), .smp_in(smp_in),
    .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .wr_data(ram_wdata)
  );

  sdl_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_s2), .adv(wr_cyc), .addr(addr), .filled(filled)
  );

  sdl_out #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk(clk), .rst_n(rst_s2), .load(wr_cyc), .live(filled),
    .rdata(ram_rdata), .out_sample(out_sample), .out_valid(out_valid)
  );

  generate
    if (DEPTH_SHIFT > 0) begin : g_narrow
      assign ram_addr = {{DEPTH_SHIFT{1'b0}}, addr};
    end else begin : g_full
      assign ram_addr = addr;
    end
  endgenerate

  assign ram_we = wr_cyc;

  // R2
  write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    ram_we |-> ($past(rd_cyc) && $stable(ram_addr)));

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    out_valid |=> !out_valid);
endmodule

// File: tb/sample_delay_line_test.sv
`timescale 1ns/1ps
module sample_delay_line_test;
  localparam int SW    = 8;
  localparam int FW    = 6;
  localparam int SHIFT = 2;
  localparam int DEPTH = 1 << (FW - SHIFT);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_strobe;
  logic [SW-1:0] smp_in;
  logic [SW-1:0] out_sample;
  logic          out_valid;
  logic [FW-1:0] ram_addr;
  logic [SW-1:0] ram_wdata;
  logic          ram_we;
  logic [SW-1:0] ram_rdata;

  logic [SW-1:0] mem [0:(1<<FW)-1];

  int checks = 0;
  int errors = 0;
  int nsent  = 0;
  bit mon_on = 1'b0;
  logic [SW-1:0] hist [0:1023];
  logic [SW-1:0] exp_out_q [$];
  logic [SW-1:0] exp_wd_q  [$];
  logic [FW-1:0] exp_wa_q  [$];
  logic [SW-1:0] last_out;

  always #4 clk = ~clk;

  sample_delay_line #(.SAMPLE_W(SW), .FULL_ADDR_W(FW), .DEPTH_SHIFT(SHIFT)) uut (
    .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .smp_in(smp_in),
    .out_sample(out_sample), .out_valid(out_valid), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    else        ram_rdata     <= mem[ram_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [SW-1:0] s, input int gap, input bit chk_lat);
    smp_strobe = 1'b1;
    smp_in     = s;
    hist[nsent] = s;
    exp_out_q.push_back(nsent < DEPTH ? 8'h80 : hist[nsent - DEPTH]);
    exp_wd_q.push_back(s);
    exp_wa_q.push_back(FW'(nsent % DEPTH));
    nsent++;
    @(negedge clk);
    smp_strobe = 1'b0;
    if (chk_lat) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R5 early", out_valid, 0);
      @(negedge clk);
      check(out_valid == 1'b1, "R5 latency", out_valid, 1);
      repeat (gap - 3) @(negedge clk);
    end else begin
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (ram_we) begin
        if (exp_wa_q.size() == 0) begin
          check(1'b0, "R2 extra write", 1, 0);
        end else begin
          automatic logic [FW-1:0] ea = exp_wa_q.pop_front();
          automatic logic [SW-1:0] ed = exp_wd_q.pop_front();
          check(ram_addr == ea, "R1 addr", ram_addr, ea);
          check(ram_wdata == ed, "R2 wdata", ram_wdata, ed);
        end
      end
      if (out_valid) begin
        if (exp_out_q.size() == 0) begin
          check(1'b0, "R6 extra output", 1, 0);
        end else begin
          automatic logic [SW-1:0] eo = exp_out_q.pop_front();
          check(out_sample == eo, "R3/R4 out", out_sample, eo);
        end
      end else begin
        check(out_sample == last_out, "R5 hold", out_sample, last_out);
      end
      last_out = out_sample;
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    smp_strobe = 1'b0;
    smp_in = '0;
    repeat (3) @(negedge clk);
    // R7 during reset
    check(out_sample == 8'h80, "R7 out", out_sample, 8'h80);
    check(out_valid == 1'b0, "R7 valid", out_valid, 0);
    check(ram_we == 1'b0, "R7 we", ram_we, 0);
    check(ram_addr == '0, "R7 addr", ram_addr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_sample == 8'h80 && !out_valid && !ram_we && ram_addr == '0,
          "R7 after release", out_sample, 8'h80);
    last_out = out_sample;
    mon_on = 1'b1;

    // R4 / R5: widely spaced strobes, latency checked, across first wrap
    for (int i = 0; i < 24; i++) send(SW'(8'h11 * i + 8'h03), 6, 1'b1);
    // R3: spacing 2
    for (int i = 0; i < 24; i++) send(SW'(8'hA5 ^ (i * 7)), 2, 1'b0);
    // R6: adjacent pairs then gap of 3
    for (int i = 0; i < 20; i++) begin
      send(SW'(i * 13), 1, 1'b0);
      send(SW'(8'hFF - i), 3, 1'b0);
    end
    // R3: extremes and irregular spacing
    for (int i = 0; i < 20; i++) send((i % 2) ? 8'hFF : 8'h00, 2 + (i % 5), 1'b0);
    repeat (10) @(negedge clk);
    check(exp_out_q.size() == 0, "R6 outputs pending", exp_out_q.size(), 0);
    check(exp_wa_q.size() == 0, "R2 writes pending", exp_wa_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule